// File: doc/BRIEF.md
# Write-One-to-Clear Interrupt Event Register

This block holds a 32-bit register of pending interrupt events together with a 32-bit mask register, and drives one level-sensitive interrupt line. Each hardware event input is a single-cycle pulse that sets its bit. The bit then stays set until software clears it. Software clears bits by writing ones to the event register. Zeros in the written word leave their bits alone. Software can therefore read the whole register and write the same word back to acknowledge exactly the events it saw. Any event that arrives after the read stays pending.

A small register port reaches both registers: a select, a write flag, a byte address, write data and combinational read data. A run-time input selects a legacy mode in which reading the event register clears it. That mode is there to show the failure it causes: a hardware event that lands in the same cycle as the read is lost.

Top module: `irq_event_reg`

## Requirements
- R1: A synchronous active-low reset clears every event bit and every mask bit, so that `irq` reads 0.
- R2: A one-cycle pulse on `evt_in[i]` sets event bit i at the next rising clock edge. The bit stays set until it is cleared.
- R3: A write to the event register (byte address 0x0) clears each bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: When a pulse on `evt_in[i]` and a write of 1 to event bit i occur in the same cycle, the bit is 1 after the edge.
- R5: With `legacy_rtc`=0, a read of the event register returns every pending bit in the same cycle and changes no bit.
- R6: If software reads the event register and later writes the value it read, only the bits it saw are cleared. An event that arrived between the read and the write stays pending.
- R7: The mask register (byte address 0x4) is a plain read/write register. It changes only when it is written.
- R8: `irq` is 1 exactly when at least one event bit is set whose mask bit is also 1.
- R9: With `legacy_rtc`=1, a read of the event register returns the pending bits and clears all of them at the next edge. This includes a bit whose `evt_in` pulse arrives in the same cycle, so that event is lost.
- R10: Reads of any other address return 0, and writes to it change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_in | input | 32 | Hardware event pulses, one per bit |
| legacy_rtc | input | 1 | 1 selects the read-to-clear mode for the event register |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address: 0x0 events, 0x4 mask |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current access, 0 when idle |
| irq | output | 1 | Combined masked interrupt level |

## Verification
The bench targets a hardware set and a write-one clear that hit the same bit in one cycle. A design that gave the clear priority would drop that event and read back 0. It also runs the read, new event, write-back sequence. A design that cleared unwritten bits, or that cleared bits on a read, would lose the late event. It then sets up the same collision with a read in legacy mode and checks that the new event is gone, and checks that the same collision in the normal mode keeps the event. Masking is checked in both directions on `irq`, and unmapped addresses are checked for a zero read and for writes that have no effect.

// File: rtl/irq_evt_pkg.sv
// Shared types for the interrupt event register.
// Assumes nothing beyond a standard SystemVerilog package scope.
package irq_evt_pkg;
    // Which register the current bus access targets.
    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_EVENT = 2'd1,
        SEL_MASK  = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/irq_bus_decode.sv
// Decodes a bus access into register strobes.
// Assumes one access per cycle and a combinational reply.
module irq_bus_decode
    import irq_evt_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int EVT_OFS  = 0,
    parameter int MASK_OFS = 4
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              legacy_rtc,
    output reg_sel_e          target,
    output logic              evt_w1c_en,
    output logic              mask_wr_en,
    output logic              evt_rd_clr
);
    localparam logic [ADDR_W-1:0] EVT_A  = ADDR_W'(EVT_OFS);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

    // Address match to register select.
    always_comb begin
        if (!bus_sel)                target = SEL_NONE;
        else if (bus_addr == EVT_A)  target = SEL_EVENT;
        else if (bus_addr == MASK_A) target = SEL_MASK;
        else                         target = SEL_NONE;
    end

    // Strobes for write-one-clear, mask write and legacy read-clear.
    always_comb begin
        evt_w1c_en = (target == SEL_EVENT) && bus_wr;
        mask_wr_en = (target == SEL_MASK) && bus_wr;
        evt_rd_clr = (target == SEL_EVENT) && !bus_wr && legacy_rtc;
    end
endmodule

// File: rtl/irq_evt_cell.sv
// One sticky event bit.
// A set normally wins over a write-one clear. The legacy read-clear is
// the exception: it wins over a set and so reproduces the lost event.
module irq_evt_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic w1c_i,
    input  logic rdclr_i,
    output logic q
);
    // Bit state update with the priorities above.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= 1'b0;
        else if (rdclr_i) q <= 1'b0;
        else if (set_i)   q <= 1'b1;
        else if (w1c_i)   q <= 1'b0;
    end
endmodule

// File: rtl/irq_evt_bank.sv
// The event register, one cell per bit.
// Assumes evt_in pulses last one cycle. A longer pulse only re-sets the bit.
module irq_evt_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt_in,
    input  logic             w1c_en,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd_clr,
    output logic [WIDTH-1:0] evt_q
);
    // Per-bit clear request from a write-one access.
    logic [WIDTH-1:0] clr_bits;

    // Gate write data into clear requests.
    always_comb clr_bits = w1c_en ? wdata : '0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        irq_evt_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (evt_in[i]),
            .w1c_i   (clr_bits[i]),
            .rdclr_i (rd_clr),
            .q       (evt_q[i])
        );
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Plain read/write mask register.
// Assumes a write strobe lasts one cycle.
module irq_mask_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] mask_q
);
    // Load on write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     mask_q <= '0;
        else if (wr_en) mask_q <= wdata;
    end
endmodule

// File: rtl/irq_event_reg.sv
// Interrupt event register with write-one-to-clear, a mask and a level output.
// Assumes a single bus master and one access per cycle. Read data is
// combinational from the current register values.
module irq_event_reg
    import irq_evt_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int ADDR_W   = 4,
    parameter int EVT_OFS  = 0,
    parameter int MASK_OFS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  evt_in,
    input  logic              legacy_rtc,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic              irq
);
    reg_sel_e         target;
    logic             evt_w1c_en;
    logic             mask_wr_en;
    logic             evt_rd_clr;
    logic [WIDTH-1:0] evt_q;
    logic [WIDTH-1:0] mask_q;

    irq_bus_decode #(
        .ADDR_W   (ADDR_W),
        .EVT_OFS  (EVT_OFS),
        .MASK_OFS (MASK_OFS)
    ) u_dec (
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .legacy_rtc (legacy_rtc),
        .target     (target),
        .evt_w1c_en (evt_w1c_en),
        .mask_wr_en (mask_wr_en),
        .evt_rd_clr (evt_rd_clr)
    );

    irq_evt_bank #(.WIDTH(WIDTH)) u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_in (evt_in),
        .w1c_en (evt_w1c_en),
        .wdata  (bus_wdata),
        .rd_clr (evt_rd_clr),
        .evt_q  (evt_q)
    );

    irq_mask_reg #(.WIDTH(WIDTH)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mask_wr_en),
        .wdata  (bus_wdata),
        .mask_q (mask_q)
    );

    // Read mux; data only during a read access.
    always_comb begin
        bus_rdata = '0;
        if (!bus_wr) begin
            case (target)
                SEL_EVENT: bus_rdata = evt_q;
                SEL_MASK:  bus_rdata = mask_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    // Masked OR of pending events.
    always_comb irq = |(evt_q & mask_q);
endmodule

// File: rtl/irq_event_chk.sv
// Property checker for irq_event_reg, bound to every instance.
// Reads top-level state only; it drives nothing.
module irq_event_chk #(
    parameter int WIDTH    = 32,
    parameter int ADDR_W   = 4,
    parameter int EVT_OFS  = 0,
    parameter int MASK_OFS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WIDTH-1:0]  evt_in,
    input logic              legacy_rtc,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic              irq,
    input logic [WIDTH-1:0]  evt_q,
    input logic [WIDTH-1:0]  mask_q
);
    localparam logic [ADDR_W-1:0] EA = ADDR_W'(EVT_OFS);
    localparam logic [ADDR_W-1:0] MA = ADDR_W'(MASK_OFS);

    logic             acc_evt, acc_mask, legacy_rd;
    logic [WIDTH-1:0] may_clear;

    // Bus classification seen from the ports.
    always_comb begin
        acc_evt   = bus_sel && (bus_addr == EA);
        acc_mask  = bus_sel && (bus_addr == MA);
        legacy_rd = acc_evt && !bus_wr && legacy_rtc;
        if (legacy_rd)              may_clear = '1;
        else if (acc_evt && bus_wr) may_clear = bus_wdata;
        else                        may_clear = '0;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (evt_q == '0 && mask_q == '0)); // R1

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        !legacy_rd |=> ((evt_q & $past(evt_in)) == $past(evt_in))); // R4

    AST_CLEAR_ONLY_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(evt_q) & ~evt_q) & ~$past(may_clear)) == '0)); // R3

    AST_READ_NO_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_evt && !bus_wr && !legacy_rtc) |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R5

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_mask && bus_wr) |=> $stable(mask_q)); // R7

    AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (evt_q != '0 && mask_q != '0)); // R8

    AST_LEGACY_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_rd |=> (evt_q == '0)); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !acc_evt && !acc_mask) |-> (bus_rdata == '0)); // R10
endmodule

bind irq_event_reg irq_event_chk #(
    .WIDTH    (WIDTH),
    .ADDR_W   (ADDR_W),
    .EVT_OFS  (EVT_OFS),
    .MASK_OFS (MASK_OFS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_in     (evt_in),
    .legacy_rtc (legacy_rtc),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .evt_q      (evt_q),
    .mask_q     (mask_q)
);

// File: tb/sim_irq_event_reg.sv
module sim_irq_event_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_in = '0;
    logic        legacy_rtc = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Reference state
    logic [31:0] m_evt = '0;
    logic [31:0] m_mask = '0;

    always #10 clk = ~clk;

    irq_event_reg u0 (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .legacy_rtc(legacy_rtc),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model update and per-cycle comparison.
    always @(posedge clk) begin
        logic [31:0] nxt;
        nxt = m_evt;
        if (!rst_n) begin
            m_evt  = '0;
            m_mask = '0;
        end else begin
            if (bus_sel && bus_wr && bus_addr == 4'h0) nxt = nxt & ~bus_wdata;
            nxt = nxt | evt_in;
            if (bus_sel && !bus_wr && bus_addr == 4'h0 && legacy_rtc) nxt = '0;
            if (bus_sel && bus_wr && bus_addr == 4'h4) m_mask = bus_wdata;
            m_evt = nxt;
        end
        #2;
        chk("R8 model irq", {31'd0, irq}, {31'd0, (m_evt & m_mask) != 0});
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d, input logic [31:0] pulse);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; evt_in = pulse;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_wdata = '0; evt_in = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [31:0] pulse, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a; evt_in = pulse;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0; evt_in = '0;
    endtask

    task automatic pulse_evt(input logic [31:0] p);
        @(negedge clk);
        evt_in = p;
        @(negedge clk);
        evt_in = '0;
    endtask

    initial begin
        logic [31:0] d, seen;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        bus_read(4'h0, '0, d); chk("R1 events after reset", d, 32'h0);
        bus_read(4'h4, '0, d); chk("R1 mask after reset", d, 32'h0);
        chk("R1 irq after reset", {31'd0, irq}, 32'h0);

        // R2 set by pulse, sticky
        pulse_evt(32'h0000_0005);
        repeat (2) @(negedge clk);
        bus_read(4'h0, '0, d); chk("R2 pulse sets bits", d, 32'h5);
        chk("R8 masked off", {31'd0, irq}, 32'h0);

        // R7 mask read/write, R8 irq
        bus_write(4'h4, 32'h0000_0001, '0);
        bus_read(4'h4, '0, d); chk("R7 mask readback", d, 32'h1);
        chk("R8 irq with mask", {31'd0, irq}, 32'h1);

        // R3 write-one clears only ones
        bus_write(4'h0, 32'h0000_0004, '0);
        bus_read(4'h0, '0, d); chk("R3 partial clear", d, 32'h1);
        bus_write(4'h0, 32'h0000_0001, '0);
        bus_read(4'h0, '0, d); chk("R3 full clear", d, 32'h0);
        chk("R8 irq drops", {31'd0, irq}, 32'h0);

        // R4 set vs clear collision
        bus_write(4'h0, 32'h0000_0008, 32'h0000_0008);
        bus_read(4'h0, '0, d); chk("R4 set wins over clear", d, 32'h8);

        // R5 read has no side effect; R6 read then write-back
        bus_read(4'h0, '0, seen); chk("R5 read returns pending", seen, 32'h8);
        bus_read(4'h0, '0, d); chk("R5 second read unchanged", d, 32'h8);
        pulse_evt(32'h0000_0080);
        bus_write(4'h0, seen, '0);
        bus_read(4'h0, '0, d); chk("R6 late event kept", d, 32'h80);
        bus_write(4'h0, 32'h0000_0080, '0);

        // R5 read colliding with a set in normal mode keeps it
        pulse_evt(32'h0000_0004);
        bus_read(4'h0, 32'h0000_0200, d); chk("R5 read value", d, 32'h4);
        bus_read(4'h0, '0, d); chk("R5 collision kept", d, 32'h204);
        bus_write(4'h0, 32'hFFFF_FFFF, '0);

        // R9 legacy read-to-clear loses the colliding event
        legacy_rtc = 1;
        pulse_evt(32'h0000_0004);
        bus_read(4'h0, 32'h0000_0200, d); chk("R9 legacy read value", d, 32'h4);
        bus_read(4'h0, '0, d); chk("R9 colliding event lost", d, 32'h0);
        legacy_rtc = 0;

        // R10 unmapped address
        pulse_evt(32'h0000_0010);
        bus_write(4'h8, 32'hFFFF_FFFF, '0);
        bus_read(4'h8, '0, d); chk("R10 unmapped reads zero", d, 32'h0);
        bus_read(4'h0, '0, d); chk("R10 events untouched", d, 32'h10);
        bus_read(4'h4, '0, d); chk("R10 mask untouched", d, 32'h1);

        // R1 reset in mid-run
        bus_write(4'h4, 32'hFFFF_FFFF, '0);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        bus_read(4'h0, '0, d); chk("R1 events after mid reset", d, 32'h0);
        bus_read(4'h4, '0, d); chk("R1 mask after mid reset", d, 32'h0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule